// File: doc/BRIEF.md
# Carrier PWM Duty Sequencer for a Two-Interval Rectifier Inverter Stage

This block turns one switching period's worth of duty information into a timed train of inverter states for a single three-leg output stage. The DC link of that stage comes from a rectifier stage that spends a fraction gamma of each period on one line-voltage pair and the rest, delta, on another. Each period the block receives three leg duties and the gamma fraction. It ranks the legs by duty and splits the period into a low zero part, two active parts and a high zero part. It scales every part by gamma and again by delta, and plays the resulting segments out one tick per clock.

The segments run in a symmetric order: the gamma half runs from all-low through the active states to all-high, and the delta half mirrors it. The switch from the gamma interval to the delta interval falls between the two halves of the all-high vector, so the rectifier changes over while the inverter draws no link current. A controller pulses `start` once per period with fresh duties. The block holds those duties for the whole period, reports `busy`, and marks the rectifier changeover with a one-cycle pulse. Producing the duties themselves, and inserting dead time, are left to neighbouring logic.

Top module: `cpwm_duty_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `sw_state` is 000 and `rect_delta` and `rect_commute` are 0.
- R2: A `start` sampled high at rising edge n, while idle and with `period` nonzero, is accepted. `busy` is then high after edges n+1 through n+P, where P is the latched period, and low after edge n+P+1. One output state is shown per cycle during that window.
- R3: Let M be the leg with the largest duty and D the leg with the middle duty. The bits of `sw_state` are bit 0 = leg a, bit 1 = leg b and bit 2 = leg c, with 1 meaning the upper switch is on. The states then appear in this order: 000, {M}, {M,D}, 111 (gamma half), then 111, {M,D}, {M}, 000 (delta half).
- R4: Duties and gamma are unsigned fractions of 65536, and delta = 65536 − gamma. The component fractions are: low zero = 65536 − max, alpha = max − mid, beta = mid − min, high zero = min. Each of the first seven segments lasts floor(component × fraction × P / 2^32) ticks, where the fraction is gamma in the first half and delta in the second.
- R5: The last segment (all-low, delta half) takes P minus the sum of the other seven, so the states total exactly P ticks.
- R6: Legs with equal duty switch together: no segment separates them.
- R7: `rect_delta` is 0 during the gamma half and 1 from the first delta-half tick to the end of the period. `rect_commute` is high for exactly that first delta-half tick. It does not pulse if the gamma half fills the whole period.
- R8: A `start` while busy is ignored, and input changes during a period have no effect; the running period completes unchanged.
- R9: A `start` with `period` equal to 0 is ignored and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM tick clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin a period with the present inputs |
| duty_a | input | DW | leg a duty, fraction of 2^DW |
| duty_b | input | DW | leg b duty, fraction of 2^DW |
| duty_c | input | DW | leg c duty, fraction of 2^DW |
| gam_frac | input | DW | rectifier gamma interval fraction of 2^DW |
| period | input | PW | period length in ticks |
| sw_state | output | 3 | upper-switch bits of legs c, b, a |
| rect_delta | output | 1 | 1 while the rectifier is in its delta interval |
| rect_commute | output | 1 | one-cycle mark of the rectifier changeover |
| busy | output | 1 | a period is being played out |

## Verification
The sequencer is driven with distinct leg rankings (a highest, c highest) so that the active states have to follow the ranking and not the leg positions. Tied legs show that the alpha segment vanishes. A zero gamma fraction moves the changeover to the very first tick. Odd periods with awkward fractions force truncation, which separates a correct remainder in the last segment from a total that drifts off the period. A restart and duty change in mid-period, and a zero period, show whether the latch and the accept logic hold the running sequence. Every tick of each period is compared with the segment timing worked out from the requirements.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // upper-switch pattern of the three legs: bit0 = a, bit1 = b, bit2 = c
  typedef logic [2:0] inv_state_t;
  localparam inv_state_t ST_LOW  = 3'b000;
  localparam inv_state_t ST_HIGH = 3'b111;
  localparam int NSEG = 8;   // segments per period
  localparam int NEND = 7;   // explicit segment end marks
  localparam int HALF = 3;   // index of the end mark closing the gamma half
endpackage

// File: rtl/cpwm_duty_split.sv
module cpwm_duty_split
  import cpwm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0][DW-1:0] legs,
  output logic [3:0][DW:0]   comps,
  output inv_state_t         st_a,
  output inv_state_t         st_b
);
  localparam logic [DW:0] ONE = {1'b1, {DW{1'b0}}};

  logic [1:0] mx, md, mn, o1, o2;

  always_comb begin
    if (legs[0] >= legs[1] && legs[0] >= legs[2]) mx = 2'd0;
    else if (legs[1] >= legs[2])                  mx = 2'd1;
    else                                          mx = 2'd2;
    case (mx)
      2'd0:    begin o1 = 2'd1; o2 = 2'd2; end
      2'd1:    begin o1 = 2'd0; o2 = 2'd2; end
      default: begin o1 = 2'd0; o2 = 2'd1; end
    endcase
    if (legs[o2] <= legs[o1]) begin mn = o2; md = o1; end
    else                      begin mn = o1; md = o2; end
    comps[0] = ONE - {1'b0, legs[mx]};
    comps[1] = {1'b0, legs[mx]} - {1'b0, legs[md]};
    comps[2] = {1'b0, legs[md]} - {1'b0, legs[mn]};
    comps[3] = {1'b0, legs[mn]};
    st_a = inv_state_t'(3'b001 << mx);
    st_b = st_a | inv_state_t'(3'b001 << md);
  end
endmodule

// File: rtl/cpwm_seg_timer.sv
module cpwm_seg_timer
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic [3:0][DW:0]        comps,
  input  logic [DW-1:0]           gam,
  input  logic [PW-1:0]           per,
  output logic [NEND-1:0][PW-1:0] ends
);
  localparam int MW = 2 * (DW + 1) + PW;
  localparam logic [DW:0] ONE = {1'b1, {DW{1'b0}}};

  logic [DW:0] gam_w, del_w;
  logic [NEND-1:0][PW-1:0] len;

  assign gam_w = {1'b0, gam};
  assign del_w = ONE - gam_w;

  for (genvar k = 0; k < NEND; k++) begin : g_seg
    localparam int CI = (k <= HALF) ? k : (NEND - k);
    logic [MW-1:0] xe, re, prod;
    assign xe = MW'(comps[CI]);
    if (k <= HALF) begin : g_gam
      assign re = MW'(gam_w);
    end else begin : g_del
      assign re = MW'(del_w);
    end
    assign prod = xe * re * MW'(per);
    assign len[k] = prod[2*DW +: PW];
  end

  always_comb begin
    ends[0] = len[0];
    for (int k = 1; k < NEND; k++) ends[k] = ends[k-1] + len[k];
  end
endmodule

// File: rtl/cpwm_seq_player.sv
module cpwm_seq_player
  import cpwm_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [PW-1:0]           per_in,
  input  logic [PW-1:0]           per_q,
  input  logic [NEND-1:0][PW-1:0] ends,
  input  inv_state_t              st_a,
  input  inv_state_t              st_b,
  output logic                    load,
  output inv_state_t              sw_q,
  output logic                    rect_q,
  output logic                    com_q,
  output logic                    busy_q
);
  logic          running;
  logic [PW-1:0] t;
  logic [2:0]    cur;
  inv_state_t    st_now;

  assign load = start && !running && (per_in != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      t       <= '0;
    end else if (load) begin
      running <= 1'b1;
      t       <= '0;
    end else if (running) begin
      if (t == per_q - PW'(1)) running <= 1'b0;
      else                     t <= t + PW'(1);
    end
  end

  always_comb begin
    cur = 3'(NSEG - 1);
    for (int k = NEND - 1; k >= 0; k--) if (t < ends[k]) cur = 3'(k);
    case (cur)
      3'd1, 3'd6: st_now = st_a;
      3'd2, 3'd5: st_now = st_b;
      3'd3, 3'd4: st_now = ST_HIGH;
      default:    st_now = ST_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sw_q   <= ST_LOW;
      rect_q <= 1'b0;
      com_q  <= 1'b0;
    end else begin
      busy_q <= running;
      sw_q   <= running ? st_now : ST_LOW;
      rect_q <= running && (t >= ends[HALF]);
      com_q  <= running && (t == ends[HALF]);
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (sw_q == ST_LOW && !rect_q && !com_q));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (running && $past(running)) |-> (t == $past(t) + PW'(1)));

  p_ends_fit_r5: assert property (@(posedge clk) disable iff (rst)
    running |-> (ends[HALF] <= ends[NEND-1] && ends[NEND-1] <= per_q));

  p_commute_edge_r7: assert property (@(posedge clk) disable iff (rst)
    com_q |-> (rect_q && !$past(rect_q)));

  p_zero_period_r9: assert property (@(posedge clk) disable iff (rst)
    (start && per_in == '0 && !running) |=> !running);
endmodule

// File: rtl/cpwm_duty_seq.sv
module cpwm_duty_seq
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] duty_a,
  input  logic [DW-1:0] duty_b,
  input  logic [DW-1:0] duty_c,
  input  logic [DW-1:0] gam_frac,
  input  logic [PW-1:0] period,
  output logic [2:0]    sw_state,
  output logic          rect_delta,
  output logic          rect_commute,
  output logic          busy
);
  logic [2:0][DW-1:0]       legs_q;
  logic [DW-1:0]            gam_q;
  logic [PW-1:0]            per_q;
  logic                     load;
  logic [3:0][DW:0]         comps;
  logic [NEND-1:0][PW-1:0]  ends;
  inv_state_t               st_a, st_b, sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      legs_q <= '0;
      gam_q  <= '0;
      per_q  <= '0;
    end else if (load) begin
      legs_q <= {duty_c, duty_b, duty_a};
      gam_q  <= gam_frac;
      per_q  <= period;
    end
  end

  cpwm_duty_split #(.DW(DW)) u_split (
    .legs(legs_q), .comps(comps), .st_a(st_a), .st_b(st_b)
  );

  cpwm_seg_timer #(.DW(DW), .PW(PW)) u_timer (
    .comps(comps), .gam(gam_q), .per(per_q), .ends(ends)
  );

  cpwm_seq_player #(.PW(PW)) u_player (
    .clk(clk), .rst(rst), .start(start), .per_in(period), .per_q(per_q),
    .ends(ends), .st_a(st_a), .st_b(st_b), .load(load), .sw_q(sw_q),
    .rect_q(rect_delta), .com_q(rect_commute), .busy_q(busy)
  );

  assign sw_state = sw_q;
endmodule

// File: tb/sim_cpwm_duty_seq.sv
module sim_cpwm_duty_seq;
  localparam int MAXP = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [15:0] duty_a = '0, duty_b = '0, duty_c = '0, gam_frac = '0;
  logic [15:0] period = '0;
  logic [2:0] sw_state;
  logic rect_delta, rect_commute, busy;

  int tests = 0;
  int failed = 0;
  int exp_st [MAXP];

  always #5 clk = ~clk;

  cpwm_duty_seq u0 (
    .clk(clk), .rst(rst), .start(start), .duty_a(duty_a), .duty_b(duty_b),
    .duty_c(duty_c), .gam_frac(gam_frac), .period(period), .sw_state(sw_state),
    .rect_delta(rect_delta), .rect_commute(rect_commute), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Builds the expected tick-by-tick states; returns the first delta-half tick.
  function automatic int build_model(input int a, input int b, input int c,
                                     input int g, input int p);
    int v [3];
    int mxi, mdi, mni, mx, md, mn, sa, sb, acc, half;
    longint comp [4];
    longint d;
    int len [8];
    int st [8];
    v[0] = a; v[1] = b; v[2] = c;
    mxi = 0;
    for (int i = 1; i < 3; i++) if (v[i] > v[mxi]) mxi = i;
    mni = (mxi == 0) ? 1 : 0;
    for (int i = 0; i < 3; i++) if (i != mxi && v[i] < v[mni]) mni = i;
    mdi = 3 - mxi - mni;
    mx = v[mxi]; md = v[mdi]; mn = v[mni];
    comp[0] = 65536 - mx; comp[1] = mx - md; comp[2] = md - mn; comp[3] = mn;
    d = 65536 - g;
    for (int k = 0; k < 4; k++) len[k] = int'((comp[k] * g * p) >>> 32);
    for (int k = 4; k < 7; k++) len[k] = int'((comp[7-k] * d * p) >>> 32);
    acc = 0;
    for (int k = 0; k < 7; k++) acc += len[k];
    len[7] = p - acc;
    sa = 1 << mxi;
    sb = sa | (1 << mdi);
    st[0] = 0; st[1] = sa; st[2] = sb; st[3] = 7;
    st[4] = 7; st[5] = sb; st[6] = sa; st[7] = 0;
    acc = 0;
    half = len[0] + len[1] + len[2] + len[3];
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < len[k]; j++) begin
        exp_st[acc] = st[k];
        acc++;
      end
    return half;
  endfunction

  // One period; with poke set, a restart with other duties is tried mid-way.
  task automatic run_case(input int a, input int b, input int c, input int g,
                          input int p, input bit poke, input string req);
    int half, bad_st, bad_rect, bad_busy, ncom, com_at, first_bad, first_exp;
    half = build_model(a, b, c, g, p);
    bad_st = 0; bad_rect = 0; bad_busy = 0; ncom = 0; com_at = -1;
    first_bad = -1; first_exp = -1;
    duty_a = 16'(a); duty_b = 16'(b); duty_c = 16'(c);
    gam_frac = 16'(g); period = 16'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    for (int i = 0; i < p; i++) begin
      if (!busy) bad_busy++;
      if (int'(sw_state) != exp_st[i]) begin
        if (bad_st == 0) begin first_bad = int'(sw_state); first_exp = exp_st[i]; end
        bad_st++;
      end
      if (rect_delta != (i >= half)) bad_rect++;
      if (rect_commute) begin ncom++; com_at = i; end
      if (poke && i == p / 2) begin
        start = 1'b1; duty_a = 16'd100; duty_b = 16'd65000; duty_c = 16'd30000;
        gam_frac = 16'd1000; period = 16'd20;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(bad_st == 0, req, "state sequence first mismatch", first_bad, first_exp);
    chk(bad_busy == 0, "R2", "ticks without busy", bad_busy, 0);
    chk(!busy, "R2", "busy after P ticks", int'(busy), 0);
    chk(bad_rect == 0, "R7", "rect_delta mismatches", bad_rect, 0);
    chk(ncom == ((half < p) ? 1 : 0), "R7", "commute pulse count", ncom,
        (half < p) ? 1 : 0);
    if (half < p) chk(com_at == half, "R7", "commute tick", com_at, half);
    chk(sw_state == 3'b000 && !rect_delta, "R1", "idle outputs after period",
        int'(sw_state), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(!busy && sw_state == 3'b000 && !rect_delta && !rect_commute, "R1",
        "reset state", int'({busy, rect_delta, rect_commute, sw_state}), 0);
  endtask

  task automatic t_zero_period;
    int seen;
    seen = 0;
    duty_a = 16'd20000; duty_b = 16'd10000; duty_c = 16'd5000;
    gam_frac = 16'd30000; period = 16'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (busy) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R9", "busy cycles after zero-period start", seen, 0);
  endtask

  initial begin
    #(200000 * 10);
    failed++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    // R3: leg a ranks highest
    run_case(40000, 20000, 10000, 30000, 200, 1'b0, "R3");
    // R3 and R4: leg c ranks highest, leg a lowest
    run_case(5000, 30000, 60000, 50000, 333, 1'b0, "R4");
    // R6: tied legs a and b
    run_case(30000, 30000, 10000, 40000, 150, 1'b0, "R6");
    // R7: zero gamma moves the changeover to tick 0
    run_case(25000, 45000, 12000, 0, 120, 1'b0, "R7");
    // R5: odd period with truncating fractions
    run_case(65535, 1, 33333, 12345, 97, 1'b0, "R5");
    // R8: restart with new inputs during the period is ignored
    run_case(50000, 15000, 35000, 20000, 180, 1'b1, "R8");
    // R9: zero period
    t_zero_period();
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule